// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block sits between a pixel scanout stream and a video output path. Each accepted pixel word is reduced to 8-bit red, green and blue values. A small set of configuration registers controls the extraction. A format register gives the number of bytes that carry pixel data. Three channel select registers give, for each of red, green and blue, where the channel's field starts, how many bits it spans, and a fallback 8-bit value. The fallback replaces the extracted value when the channel is switched off (zero width), when the pixel lies outside the visible area, or when the upstream stream has underrun.

Pixels enter on a valid/ready stream. The triple leaves on a second valid/ready stream through a single register stage. Back-pressure rules: `pix_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rgb_valid` is high and `rgb_ready` is low, the output triple and `rgb_valid` hold still and no new pixel is taken. The configuration port is a plain write strobe with no handshake. A write takes effect for pixels accepted in later cycles.

Register addresses: 0 is the format register, 1 is blue select, 2 is green select and 3 is red select. All registers reset to zero except the format register, which resets to full word width.

Top module: `pixel_comp_extract`

## Requirements
- R1: A select register holds the fallback value in bits [23:16], the field width in bits [11:8] and the field's lowest bit index in bits [4:0]. With a 16-bit 5-6-5 layout (blue offset 0 width 5, green offset 5 width 6, red offset 11 width 5), pixel 0xF800 gives red 0xFF, green 0x00, blue 0x00, and pixel 0x07E0 gives green 0xFF.
- R2: A channel whose width field is zero outputs its fallback value, and the other channels are unaffected.
- R3: When `pix_visible` is low at acceptance, all three channels output their fallback values.
- R4: When `pix_underrun` is high at acceptance, all three channels output their fallback values.
- R5: The format register holds bytes-per-pixel minus one in bits [4:3]. Pixel bytes at or above that count read as zero, as do bit positions beyond the word.
- R6: A field narrower than 8 bits is placed in the top bits of the output, and its bits from the top down repeat into the lower bits. For example, the 5-bit value 00001 gives 0x08 and the 6-bit value 000001 gives 0x04.
- R7: A width field above 8 acts as 8, so only the 8 bits starting at the offset are used.
- R8: An accepted pixel appears on the output one cycle later with `rgb_valid` high. `rgb_valid` falls after a drain cycle that has no new pixel accepted.
- R9: `pix_ready` equals `!rgb_valid || rgb_ready`. While stalled, the output triple holds stable.
- R10: A register write in the same cycle as a pixel acceptance does not affect that pixel, but it does affect the next pixel.
- R11: After reset, `rgb_valid` is low and `pix_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 format, 1 blue, 2 green, 3 red) |
| cfg_wdata | input | 32 | Register write data |
| pix_data | input | PIX_W | Raw pixel word |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word accepted when high with valid |
| pix_visible | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Upstream stream has underrun for this pixel |
| rgb_valid | output | 1 | Output triple valid |
| rgb_ready | input | 1 | Downstream takes the triple |
| rgb_r | output | 8 | Red component |
| rgb_g | output | 8 | Green component |
| rgb_b | output | 8 | Blue component |

## Verification
Two events can land in the same cycle: a register write and a pixel acceptance. When they do, the pixel must still be extracted with the settings that were in force before the write. The bench provokes this in a directed step: it rewrites the red select register while a pixel is accepted, and it also does so in random traffic, where roughly one cycle in ten carries a write. The result is judged against a reference model that computes each expected triple first and only then applies the write.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int CH_OUT_W = 8;
  localparam int WID_W    = 4;
  localparam int OFS_W    = 5;
  localparam int ADDR_W   = 2;
  localparam int NUM_CH   = 3;
  localparam int CH_B     = 0;
  localparam int CH_G     = 1;
  localparam int CH_R     = 2;

  // bit positions inside a select register word
  localparam int DFLT_LSB = 16;
  localparam int WID_LSB  = 8;
  localparam int OFS_LSB  = 0;
  // lowest bit of the bytes-per-pixel-minus-one field
  localparam int FMT_LSB  = 3;

  typedef struct packed {
    logic [CH_OUT_W-1:0] dflt;
    logic [WID_W-1:0]    width;
    logic [OFS_W-1:0]    ofs;
  } chan_sel_t;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FMT   = 2'd0,
    ADDR_SEL_B = 2'd1,
    ADDR_SEL_G = 2'd2,
    ADDR_SEL_R = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/pxc_cfg_regs.sv
module pxc_cfg_regs
  import pxc_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int BPP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output logic [BPP_W-1:0]  bpp_m1,
  output chan_sel_t         sel_q [NUM_CH]
);
  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpp_m1 <= '1;
    end else if (we && addr == ADDR_FMT) begin
      bpp_m1 <= wdata[FMT_LSB +: BPP_W];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_SEL_B + ch);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[ch] <= '0;
      end else if (we && addr == MY_ADDR) begin
        sel_q[ch].dflt  <= wdata[DFLT_LSB +: CH_OUT_W];
        sel_q[ch].width <= wdata[WID_LSB +: WID_W];
        sel_q[ch].ofs   <= wdata[OFS_LSB +: OFS_W];
      end
    end
  end
endmodule

// File: rtl/pxc_byte_mask.sv
module pxc_byte_mask #(
  parameter int PIX_W = 32,
  parameter int BPP_W = 2
) (
  input  logic [PIX_W-1:0] pix_in,
  input  logic [BPP_W-1:0] bpp_m1,
  output logic [PIX_W-1:0] pix_out
);
  localparam int NBYTES = PIX_W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [BPP_W-1:0] IDX = BPP_W'(b);
    assign pix_out[b*8 +: 8] = (IDX <= bpp_m1) ? pix_in[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/pxc_chan_extract.sv
module pxc_chan_extract
  import pxc_pkg::*;
#(
  parameter int PIX_W = 32
) (
  input  logic [PIX_W-1:0]    pix,
  input  chan_sel_t           sel,
  input  logic                blank,
  output logic [CH_OUT_W-1:0] val
);
  localparam int MASK_W = CH_OUT_W + 1;
  localparam int IDX_W  = $clog2(CH_OUT_W);

  logic [PIX_W-1:0]    shifted;
  logic [WID_W-1:0]    w_eff;
  logic [MASK_W-1:0]   mask_wide;
  logic [CH_OUT_W-1:0] field;
  logic [CH_OUT_W-1:0] rep;
  logic [IDX_W-1:0]    rep_idx;

  assign shifted   = pix >> sel.ofs;
  assign w_eff     = (sel.width > WID_W'(CH_OUT_W)) ? WID_W'(CH_OUT_W) : sel.width;
  assign mask_wide = (MASK_W'(1) << w_eff) - MASK_W'(1);
  assign field     = shifted[CH_OUT_W-1:0] & mask_wide[CH_OUT_W-1:0];

  // walk the field from its top bit downward, wrapping at the bottom
  always_comb begin
    rep     = '0;
    rep_idx = IDX_W'(w_eff - WID_W'(1));
    for (int k = 0; k < CH_OUT_W; k++) begin
      rep[CH_OUT_W-1-k] = field[rep_idx];
      if (rep_idx == '0) rep_idx = IDX_W'(w_eff - WID_W'(1));
      else               rep_idx = rep_idx - IDX_W'(1);
    end
  end

  assign val = (blank || sel.width == '0) ? sel.dflt : rep;
endmodule

// File: rtl/pxc_out_stage.sv
module pxc_out_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pixel_comp_extract.sv
module pixel_comp_extract
  import pxc_pkg::*;
#(
  parameter int PIX_W = 32,
  parameter int CFG_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [PIX_W-1:0]    pix_data,
  input  logic                pix_valid,
  output logic                pix_ready,
  input  logic                pix_visible,
  input  logic                pix_underrun,
  output logic                rgb_valid,
  input  logic                rgb_ready,
  output logic [CH_OUT_W-1:0] rgb_r,
  output logic [CH_OUT_W-1:0] rgb_g,
  output logic [CH_OUT_W-1:0] rgb_b
);
  localparam int NBYTES = PIX_W / 8;
  localparam int BPP_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int RGB_W  = NUM_CH * CH_OUT_W;

  logic [BPP_W-1:0]    bpp_m1;
  chan_sel_t           sel_q [NUM_CH];
  logic [PIX_W-1:0]    pix_masked;
  logic                blank;
  logic [CH_OUT_W-1:0] ch_val [NUM_CH];
  logic [RGB_W-1:0]    rgb_next;
  logic [RGB_W-1:0]    rgb_q;

  pxc_cfg_regs #(.CFG_W(CFG_W), .BPP_W(BPP_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .bpp_m1 (bpp_m1),
    .sel_q  (sel_q)
  );

  pxc_byte_mask #(.PIX_W(PIX_W), .BPP_W(BPP_W)) u_mask (
    .pix_in  (pix_data),
    .bpp_m1  (bpp_m1),
    .pix_out (pix_masked)
  );

  assign blank = !pix_visible || pix_underrun;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pxc_chan_extract #(.PIX_W(PIX_W)) u_ext (
      .pix   (pix_masked),
      .sel   (sel_q[ch]),
      .blank (blank),
      .val   (ch_val[ch])
    );
    assign rgb_next[ch*CH_OUT_W +: CH_OUT_W] = ch_val[ch];
  end

  pxc_out_stage #(.DATA_W(RGB_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_ready  (pix_ready),
    .in_data   (rgb_next),
    .out_valid (rgb_valid),
    .out_ready (rgb_ready),
    .out_data  (rgb_q)
  );

  assign rgb_b = rgb_q[CH_B*CH_OUT_W +: CH_OUT_W];
  assign rgb_g = rgb_q[CH_G*CH_OUT_W +: CH_OUT_W];
  assign rgb_r = rgb_q[CH_R*CH_OUT_W +: CH_OUT_W];
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker
  import pxc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pix_valid,
  input logic                pix_ready,
  input logic                pix_visible,
  input logic                pix_underrun,
  input logic                rgb_valid,
  input logic                rgb_ready,
  input logic [CH_OUT_W-1:0] rgb_r,
  input logic [CH_OUT_W-1:0] rgb_g,
  input logic [CH_OUT_W-1:0] rgb_b,
  input chan_sel_t           sel_q [NUM_CH]
);
  logic acc;
  assign acc = pix_valid && pix_ready;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rgb_valid); // R8

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && rgb_ready && !acc) |=> !rgb_valid); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid && !rgb_ready) |=> (rgb_valid && $stable(rgb_r) && $stable(rgb_g) && $stable(rgb_b))); // R9

  AST_BLANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (!pix_visible || pix_underrun)) |=>
      (rgb_r == $past(sel_q[CH_R].dflt) && rgb_g == $past(sel_q[CH_G].dflt)
       && rgb_b == $past(sel_q[CH_B].dflt))); // R3

  AST_ZERO_WIDTH_BLUE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel_q[CH_B].width == '0) |=> (rgb_b == $past(sel_q[CH_B].dflt))); // R2
endmodule

bind pixel_comp_extract pxc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_visible  (pix_visible),
  .pix_underrun (pix_underrun),
  .rgb_valid    (rgb_valid),
  .rgb_ready    (rgb_ready),
  .rgb_r        (rgb_r),
  .rgb_g        (rgb_g),
  .rgb_b        (rgb_b),
  .sel_q        (sel_q)
);

// File: tb/sim_pixel_comp_extract.sv
module sim_pixel_comp_extract;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic        pix_visible = 1'b1;
  logic        pix_underrun = 1'b0;
  logic        rgb_valid;
  logic        rgb_ready = 1'b0;
  logic [7:0]  rgb_r, rgb_g, rgb_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side register shadow and output model
  logic [1:0]  m_bm1 = 2'd3;
  logic [31:0] m_sel [3] = '{32'h0, 32'h0, 32'h0};
  logic        m_v = 1'b0;
  logic [23:0] m_d = '0;

  always #4 clk = ~clk;

  pixel_comp_extract u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_visible(pix_visible), .pix_underrun(pix_underrun),
    .rgb_valid(rgb_valid), .rgb_ready(rgb_ready),
    .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
  );

  function automatic logic [7:0] chan_exp(logic [31:0] pix, logic [1:0] bm1,
                                          logic [31:0] sel, logic blank);
    int w = int'(sel[11:8]);
    int o = int'(sel[4:0]);
    logic [31:0] m = pix;
    logic [7:0] r = '0;
    if (blank || w == 0) return sel[23:16];
    if (w > 8) w = 8;
    for (int b = 0; b < 4; b++) if (b > int'(bm1)) m[b*8 +: 8] = 8'h00;
    for (int k = 0; k < 8; k++) begin
      int pos = o + (w - 1 - (k % w));
      r[7-k] = (pos < 32) ? m[pos] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [23:0] rgb_exp(logic [31:0] pix, logic blank);
    return {chan_exp(pix, m_bm1, m_sel[2], blank),
            chan_exp(pix, m_bm1, m_sel[1], blank),
            chan_exp(pix, m_bm1, m_sel[0], blank)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(logic vld, logic [31:0] pix, logic vis, logic und, logic rdy,
                      logic we, logic [1:0] addr, logic [31:0] wd, string tag);
    logic acc;
    logic [23:0] e;
    pix_valid = vld; pix_data = pix; pix_visible = vis; pix_underrun = und;
    rgb_ready = rdy; cfg_we = we; cfg_addr = addr; cfg_wdata = wd;
    #1;
    chk("R9 pix_ready", {31'd0, pix_ready}, {31'd0, (!m_v || rdy)});
    acc = vld && (!m_v || rdy);
    e = rgb_exp(pix, !vis || und);   // R10: uses settings before this write
    if (acc) begin m_v = 1'b1; m_d = e; end
    else if (rdy) m_v = 1'b0;
    if (we) begin
      if (addr == 2'd0) m_bm1 = wd[4:3];
      else m_sel[addr - 2'd1] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8 rgb_valid", {31'd0, rgb_valid}, {31'd0, m_v});
    if (m_v) chk(tag, {8'd0, rgb_r, rgb_g, rgb_b}, {8'd0, m_d});
  endtask

  task automatic wr(logic [1:0] addr, logic [31:0] wd);
    step(1'b0, 32'd0, 1'b1, 1'b0, 1'b1, 1'b1, addr, wd, "R1 cfg");
  endtask

  task automatic px(logic [31:0] pix, logic vis, logic und, string tag);
    step(1'b1, pix, vis, und, 1'b1, 1'b0, 2'd0, 32'd0, tag);
  endtask

  function automatic logic [31:0] sel_word(logic [7:0] d, logic [3:0] w, logic [4:0] o);
    return {8'd0, d, 4'd0, w, 3'd0, o};
  endfunction

  task automatic lit(string tag, logic [23:0] exp);
    chk(tag, {8'd0, rgb_r, rgb_g, rgb_b}, {8'd0, exp});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R11 rgb_valid", {31'd0, rgb_valid}, 32'd0);
    chk("R11 pix_ready", {31'd0, pix_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 5-6-5 layout, two bytes per pixel
    wr(2'd0, 32'd1 << 3);
    wr(2'd1, sel_word(8'h00, 4'd5, 5'd0));
    wr(2'd2, sel_word(8'h00, 4'd6, 5'd5));
    wr(2'd3, sel_word(8'h00, 4'd5, 5'd11));
    px(32'h0000_F800, 1, 0, "R1 red");   lit("R1 red lit", 24'hFF0000);
    px(32'h0000_07E0, 1, 0, "R1 green"); lit("R1 green lit", 24'h00FF00);
    px(32'h0000_0821, 1, 0, "R6 repl");  lit("R6 repl lit", 24'h080408);
    px(32'hFFFF_0000, 1, 0, "R5 mask");  lit("R5 mask lit", 24'h000000);

    // 32-bit with alpha in the low byte
    wr(2'd0, 32'd3 << 3);
    wr(2'd1, sel_word(8'h11, 4'd8, 5'd8));
    wr(2'd2, sel_word(8'h22, 4'd8, 5'd16));
    wr(2'd3, sel_word(8'h33, 4'd8, 5'd24));
    px(32'h1122_3344, 1, 0, "R1 argb"); lit("R1 argb lit", 24'h112233);
    wr(2'd0, 32'd2 << 3);
    px(32'h1122_3344, 1, 0, "R5 3byte"); lit("R5 3byte lit", 24'h002233);
    wr(2'd0, 32'd3 << 3);
    px(32'hAABB_CCDD, 0, 0, "R3 blank"); lit("R3 blank lit", 24'h332211);
    px(32'hAABB_CCDD, 1, 1, "R4 under"); lit("R4 under lit", 24'h332211);
    px(32'hAABB_CCDD, 0, 1, "R3 R4 both"); lit("R4 both lit", 24'h332211);
    wr(2'd1, sel_word(8'h11, 4'd12, 5'd8));
    px(32'h1122_3344, 1, 0, "R7 wide"); lit("R7 wide lit", 24'h112233);
    wr(2'd2, sel_word(8'h5A, 4'd0, 5'd16));
    px(32'h1122_3344, 1, 0, "R2 zero"); lit("R2 zero lit", 24'h115A33);
    wr(2'd2, sel_word(8'h22, 4'd8, 5'd16));

    // R10 write to red select in the same cycle as a pixel
    step(1, 32'h1122_3344, 1, 0, 1, 1, 2'd3, sel_word(8'h77, 4'd0, 5'd0), "R10 same");
    lit("R10 same lit", 24'h112233);
    px(32'h1122_3344, 1, 0, "R10 next"); lit("R10 next lit", 24'h772233);

    // R9 stall then drain
    step(1, 32'h0102_0304, 1, 0, 0, 0, 2'd0, 32'd0, "R9 stall load");
    step(1, 32'hFFFF_FFFF, 1, 0, 0, 0, 2'd0, 32'd0, "R9 stall hold");
    step(0, 32'd0, 1, 0, 1, 0, 2'd0, 32'd0, "R8 drain");
    step(0, 32'd0, 1, 0, 1, 0, 2'd0, 32'd0, "R8 empty");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic we = ($urandom % 10) == 0;
      logic [1:0] a = 2'($urandom);
      logic [31:0] wd = $urandom;
      step(1'($urandom % 4 != 0), $urandom, 1'($urandom % 6 != 0), 1'($urandom % 8 == 0),
           1'($urandom % 3 != 0), we, a, wd, "R1 R6 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule